// File: doc/BRIEF.md
# Fractional High-Speed UART Baud Generator

This block turns a reference clock into UART bit timing. A 16-bit divisor produces a tick every `divisor` clocks, and a bit lasts a whole number of these ticks. In classic mode a bit is always 16 ticks long, and the receiver samples on tick 7 of each bit. In high-speed mode the bit length and the receive sample tick are both programmable. A 10-bit fractional mask can also add one tick to selected bits of a 10-bit frame. Spreading these extra ticks over the frame keeps the average bit rate close to a target that the integer divisor cannot reach on its own.

A small write port sets the timing registers. The port uses a word index, so the byte address is four times the index. The transmit side runs without stopping and produces a strobe at the end of every bit. The receive side waits for a falling edge on the serial line, then times one 10-bit frame from that edge and produces one sample strobe per bit. Any register write restarts both timelines, so a new setting always starts from a clean bit boundary.

Top module: `baud_gen`

## Requirements
- R1: After reset the block is in classic mode with a divisor of 1, and `txBitStrobe` pulses every 16 clocks. The reset register values are sample count 0x00, sample point 0xFF, both fraction registers 0x00 and the line-control latch bit clear.
- R2: In classic mode a bit lasts 16 divisor ticks. One divisor tick lasts D clocks, where D is {index 1, index 0}. A divisor of 0 behaves as 1.
- R3: Writes to index 0 (divisor low byte) and index 1 (divisor high byte) take effect only while bit 7 of the line-control register at index 3 is set. Otherwise these writes are ignored.
- R4: A mode register (index 0x09) value of exactly 3 selects high-speed mode. In this mode a bit lasts (sample count + 1) divisor ticks, with the sample count at index 0x0A. Any other mode value gives classic timing.
- R5: In high-speed mode the mask is {fraction high[1:0] at index 0x16, fraction low at index 0x15}. Mask bit n adds one divisor tick to frame bit n, where bit 0 is the start bit. The frame bit position returns to 0 after bit 9. The mask has no effect in classic mode.
- R6: The receive sample strobe fires on the divisor tick where the 0-based in-bit tick count equals the sample point (index 0x0B) in high-speed mode, or equals 7 in classic mode. If the sample point lies beyond the last tick of the bit, no strobe fires.
- R7: The line input passes through a two-stage synchronizer. A falling edge seen while the receiver is idle starts a 10-bit receive frame, timed from the cycle in which the edge is detected. The receiver returns to idle at the end of bit 9. Edges seen during a frame are ignored, and no sample strobe fires while idle.
- R8: Any register write restarts transmit timing at frame bit 0 and returns the receiver to idle. Neither strobe fires in the cycle of the write.
- R9: The transmit strobe pulses at the end of every bit without gaps, cycling through frame bits 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word index |
| regWdata | input | 8 | Register write data |
| rxIn | input | 1 | Serial receive line, idle high |
| txBitStrobe | output | 1 | One-cycle pulse at the end of each transmit bit |
| rxSample | output | 1 | One-cycle pulse at the receive sample point |

## Verification
A wrong divisor, tick count or stretch bit moves a strobe edge within the bit it affects. The bench tracks expected edges every cycle, so the error appears as a miscompare at the first misplaced strobe, no later than one bit time. A wrong frame-bit index or a wrong receiver idle/active state shows up when a stretched bit lands on the wrong position, or when a sample strobe appears while idle or goes missing after a start edge. Both are visible within one 10-bit frame. Ignored divisor writes and the restart on each write are confirmed by the timing of the next strobes after the write cycle.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int FRAME_BITS     = 10;
  localparam int FRAC_HI_W      = FRAME_BITS - 8;
  localparam int DIV_W          = 16;
  localparam int CNT_W          = 9;
  localparam int CLASSIC_OSR    = 16;
  localparam int CLASSIC_SAMPLE = 7;
  localparam int HS_MODE_CODE   = 3;

  localparam int OFF_DIV_LO  = 'h00;
  localparam int OFF_DIV_HI  = 'h01;
  localparam int OFF_LINECTL = 'h03;
  localparam int OFF_MODE    = 'h09;
  localparam int OFF_SCOUNT  = 'h0A;
  localparam int OFF_SPOINT  = 'h0B;
  localparam int OFF_FRAC_LO = 'h15;
  localparam int OFF_FRAC_HI = 'h16;

  typedef struct packed {
    logic                  hiSpeed;
    logic [DIV_W-1:0]      divisor;
    logic [7:0]            sampleCount;
    logic [7:0]            samplePoint;
    logic [FRAME_BITS-1:0] fracMask;
  } timingCfg_t;

  typedef struct packed {
    logic txRestart;
    logic rxRestart;
  } chanCtl_t;
endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              rxIn,
  input  logic              rxFrameDone,
  output timingCfg_t        cfg,
  output chanCtl_t          ctl
);
  logic                 dlab;
  logic [7:0]           divLo, divHi, modeReg, sCount, sPoint, fracLo;
  logic [FRAC_HI_W-1:0] fracHi;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                 rxPrev;
  logic                 rxSyncd;
  logic                 startEdge;
  logic                 rxActive;

  // register file; divisor bytes guarded by the latch bit (R3)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlab    <= 1'b0;
      divLo   <= 8'd1;
      divHi   <= 8'd0;
      modeReg <= 8'd0;
      sCount  <= 8'h00;
      sPoint  <= 8'hFF;
      fracLo  <= 8'h00;
      fracHi  <= '0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_W'(OFF_LINECTL): dlab <= regWdata[7];
        ADDR_W'(OFF_DIV_LO):  if (dlab) divLo <= regWdata;
        ADDR_W'(OFF_DIV_HI):  if (dlab) divHi <= regWdata;
        ADDR_W'(OFF_MODE):    modeReg <= regWdata;
        ADDR_W'(OFF_SCOUNT):  sCount <= regWdata;
        ADDR_W'(OFF_SPOINT):  sPoint <= regWdata;
        ADDR_W'(OFF_FRAC_LO): fracLo <= regWdata;
        ADDR_W'(OFF_FRAC_HI): fracHi <= regWdata[FRAC_HI_W-1:0];
        default: ;
      endcase
    end
  end

  // line synchronizer and start-edge detector (R7)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '1;
      rxPrev <= 1'b1;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], rxIn};
      rxPrev <= rxSyncd;
    end
  end

  assign rxSyncd   = syncQ[SYNC_STAGES-1];
  assign startEdge = rxPrev & ~rxSyncd;

  always_ff @(posedge clk) begin
    if (!rstN)                      rxActive <= 1'b0;
    else if (regWr)                 rxActive <= 1'b0;
    else if (!rxActive && startEdge) rxActive <= 1'b1;
    else if (rxActive && rxFrameDone) rxActive <= 1'b0;
  end

  always_comb begin
    cfg.hiSpeed     = (modeReg == 8'(HS_MODE_CODE));
    cfg.divisor     = {divHi, divLo};
    cfg.sampleCount = sCount;
    cfg.samplePoint = sPoint;
    cfg.fracMask    = {fracHi, fracLo};
    ctl.txRestart   = regWr;
    ctl.rxRestart   = regWr | ~rxActive;
  end
endmodule

// File: rtl/baud_gen_chan.sv
module baud_gen_chan
  import baud_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  timingCfg_t cfg,
  output logic       bitEnd,
  output logic       samplePt,
  output logic       frameDone
);
  localparam int IDX_W    = $clog2(FRAME_BITS);
  localparam int MASK_PAD = 1 << IDX_W;

  logic [DIV_W-1:0]    preCnt, divEff;
  logic                divTick;
  logic [CNT_W-1:0]    tickCnt, lastTick, sampleAt;
  logic [IDX_W-1:0]    bitIdx;
  logic [MASK_PAD-1:0] maskPad;
  logic                stretch, lastBit;

  always_comb begin
    divEff  = (cfg.divisor == '0) ? DIV_W'(1) : cfg.divisor;
    divTick = (preCnt == divEff - DIV_W'(1));
    maskPad = MASK_PAD'(cfg.fracMask);
    stretch = cfg.hiSpeed & maskPad[bitIdx];
    lastBit = (bitIdx == IDX_W'(FRAME_BITS - 1));
    if (cfg.hiSpeed) begin
      lastTick = {1'b0, cfg.sampleCount} + CNT_W'(stretch);
      sampleAt = {1'b0, cfg.samplePoint};
    end else begin
      lastTick = CNT_W'(CLASSIC_OSR - 1);
      sampleAt = CNT_W'(CLASSIC_SAMPLE);
    end
  end

  assign bitEnd    = !restart && divTick && (tickCnt == lastTick);
  assign samplePt  = !restart && divTick && (tickCnt == sampleAt);
  assign frameDone = bitEnd && lastBit;

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      preCnt  <= '0;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (divTick) begin
      preCnt <= '0;
      if (tickCnt == lastTick) begin
        tickCnt <= '0;
        bitIdx  <= lastBit ? '0 : bitIdx + IDX_W'(1);
      end else begin
        tickCnt <= tickCnt + CNT_W'(1);
      end
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              rxIn,
  output logic              txBitStrobe,
  output logic              rxSample
);
  timingCfg_t cfg;
  chanCtl_t   ctl;
  logic       rxDone;
  logic       txSampleUnused, txDoneUnused, rxBitEndUnused;

  baud_gen_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .rxIn(rxIn), .rxFrameDone(rxDone),
    .cfg(cfg), .ctl(ctl)
  );

  baud_gen_chan u_txChan (
    .clk(clk), .rstN(rstN), .restart(ctl.txRestart), .cfg(cfg),
    .bitEnd(txBitStrobe), .samplePt(txSampleUnused), .frameDone(txDoneUnused)
  );

  baud_gen_chan u_rxChan (
    .clk(clk), .rstN(rstN), .restart(ctl.rxRestart), .cfg(cfg),
    .bitEnd(rxBitEndUnused), .samplePt(rxSample), .frameDone(rxDone)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic             dlab,
  input logic [15:0]      divisor,
  input logic             hiSpeed,
  input logic             txBitStrobe,
  input logic             rxSample,
  input logic             rxActive,
  input logic [IDX_W-1:0] txIdx
);
  p_dlab_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !dlab) |=> $stable(divisor));

  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> (!txBitStrobe && !rxSample));

  p_idle_nosample_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rxActive |-> !rxSample);

  p_classic_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!hiSpeed && txBitStrobe) |=> !txBitStrobe);

  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    txIdx < IDX_W'(10));
endmodule

bind baud_gen baud_gen_chk #(.IDX_W(4)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .dlab(u_ctrl.dlab),
  .divisor(cfg.divisor), .hiSpeed(cfg.hiSpeed), .txBitStrobe(txBitStrobe),
  .rxSample(rxSample), .rxActive(u_ctrl.rxActive), .txIdx(u_txChan.bitIdx)
);

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic       rxIn = 1'b1;
  logic       txBitStrobe, rxSample;

  baud_gen dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .rxIn(rxIn), .txBitStrobe(txBitStrobe), .rxSample(rxSample)
  );

  always #4 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  string curReq = "R1";

  // behavioural model state
  int mDiv = 1, mMode = 0, mSc = 0, mSp = 255, mFrac = 0;
  bit mDlab = 0;
  int txE = 1, txIdx = 0, rxE = 1, rxIdx = 0;
  bit rxAct = 0;
  bit h0 = 1, h1 = 1, h2 = 1;

  function automatic int dEff();
    return (mDiv == 0) ? 1 : mDiv;
  endfunction

  function automatic int bitLen(int idx);
    if (mMode == 3) return mSc + 1 + ((mFrac >> idx) & 1);
    return 16;
  endfunction

  task automatic step(input bit w, input int a, input int d, input bit r);
    int  D, st;
    bit  txRst, rxRst, expTx, expRx, rxEnd, edgeNow;
    regWr = w; regAddr = 5'(a); regWdata = 8'(d); rxIn = r;
    #1;
    D = dEff();
    st = (mMode == 3) ? mSp : 7;
    txRst = w;
    rxRst = w || !rxAct;
    edgeNow = (h1 == 0) && (h2 == 1);
    expTx = !txRst && (txE == D * bitLen(txIdx));
    expRx = !rxRst && (st < bitLen(rxIdx)) && (rxE == D * (st + 1));
    rxEnd = !rxRst && (rxE == D * bitLen(rxIdx));
    vectors++;
    if (txBitStrobe !== expTx || rxSample !== expRx) begin
      errors++;
      $display("FAIL %s cycle %0d: tx=%0b rx=%0b expected tx=%0b rx=%0b",
               curReq, cycles, txBitStrobe, rxSample, expTx, expRx);
    end
    if (txRst) begin txE = 1; txIdx = 0; end
    else if (expTx) begin txE = 1; txIdx = (txIdx + 1) % 10; end
    else txE++;
    if (w) rxAct = 0;
    else if (!rxAct && edgeNow) rxAct = 1;
    else if (rxAct && rxEnd && rxIdx == 9) rxAct = 0;
    if (rxRst) begin rxE = 1; rxIdx = 0; end
    else if (rxEnd) begin rxE = 1; rxIdx = (rxIdx + 1) % 10; end
    else rxE++;
    if (w) begin
      case (a)
        3:    mDlab = d[7];
        0:    if (mDlab) mDiv = (mDiv & 'hFF00) | (d & 'hFF);
        1:    if (mDlab) mDiv = (mDiv & 'h00FF) | ((d & 'hFF) << 8);
        9:    mMode = d;
        10:   mSc = d;
        11:   mSp = d;
        'h15: mFrac = (mFrac & 'h300) | (d & 'hFF);
        'h16: mFrac = (mFrac & 'h0FF) | ((d & 3) << 8);
        default: ;
      endcase
    end
    h2 = h1; h1 = h0; h0 = r;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit r = 1'b1);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, r);
  endtask

  task automatic wr(input int a, input int d);
    step(1'b1, a, d, 1'b1);
  endtask

  task automatic setDiv(input int v);
    wr(3, 'h80); wr(0, v & 'hFF); wr(1, (v >> 8) & 'hFF); wr(3, 0);
  endtask

  task automatic rxFrame(input int lowCycles, input int rest);
    idle(lowCycles, 1'b0);
    idle(rest, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; idle(40);
    curReq = "R3"; wr(0, 5); wr(1, 2); idle(40);
    curReq = "R2"; setDiv(2); idle(70);
    setDiv(0); idle(40);
    setDiv(3); idle(100);
    curReq = "R4"; wr(9, 1); idle(60);
    wr(9, 3); wr(10, 4); wr(11, 1); setDiv(2); idle(120);
    curReq = "R5"; wr('h15, 'h55); wr('h16, 'hFF); idle(260);
    wr('h16, 1); idle(200);
    wr(9, 0); idle(80);
    curReq = "R9"; wr(9, 3); wr(10, 0); setDiv(1); idle(30);
    curReq = "R6"; wr('h15, 0); wr('h16, 0); wr(10, 7); wr(11, 3);
    rxFrame(8, 100);
    curReq = "R7"; rxFrame(8, 20); idle(3, 1'b0); idle(10, 1'b1); idle(2, 1'b0); idle(70);
    idle(5, 1'b0); idle(30);
    curReq = "R6"; wr(11, 20); rxFrame(8, 100);
    wr(11, 8); wr('h15, 'h80); rxFrame(8, 100);
    wr(9, 0); rxFrame(20, 180);
    curReq = "R8"; wr(9, 3); wr(11, 2); wr('h15, 'h0F);
    rxFrame(8, 25); wr(11, 5); idle(40); rxFrame(6, 100);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule